// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bank

This block models the digital side of four general-purpose ports on a small 8-bit controller. Every port has an output latch that the CPU writes and reads. A separate path returns the level actually present on the pins. Each pin is quasi-bidirectional. A latched 0 pulls the pin low. A latched 1 lets go of the pin, so an outside device can pull it low. Reading a pin as an input therefore only works after its latch bit holds 1.

Three ports also take on other roles. Port 0 carries the low address byte and then the data byte of an external memory cycle on the same pins. Port 2 drives the high address byte for the whole cycle. On port 3, selected bits pass an alternate-function signal gated by the latch. The pad side of each pin is given as three flags: the driven value, the drive enable and whether an internal pull-up is present. The surrounding pad or bench turns these into a resolved pin level and returns it on `pad_in`.

Top module: `qbport_bank`

## Requirements
- R1: After reset, every latch of every port reads 0xFF and no pin is driven (`pad_oe` all zero).
- R2: A write with `wr_en` high loads `wr_data` into the latch of port `wr_sel` at the clock edge. `rd_latch` returns the latch of port `rd_sel` from the next cycle on.
- R3: On ports 1 to 3, a latch bit of 0 drives its pin low (`pad_oe`=1, `pad_out`=0). `rd_pin` then reads 0 whatever an external source tries to apply.
- R4: In general use, port 0 has no pull-up (`pad_pu` bits 7:0 are 0). A latched 1 there leaves the pin undriven.
- R5: Ports 1, 2 and 3 report an internal pull-up on every pin (`pad_pu` bits 31:8 are 1). A latched 1 reads back high unless something external pulls it low.
- R6: `rd_latch` and `rd_pin` are separate paths. With latch 1 and an external low, `rd_latch` shows 1 while `rd_pin` shows 0.
- R7: While `xbus_phase` is not idle, port 2 drives `xbus_addr[15:8]` push-pull on all pins. Its latch is left unchanged, and port 2 goes back to latch control when the phase returns to idle.
- R8: `xbus_phase` is encoded as 0 idle, 1 address, 2 write data, 3 read data. In phase 1, port 0 drives `xbus_addr[7:0]`. In phase 2 it drives `xbus_wdata`. In phase 3 it releases all pins, and `xbus_rdata` returns the port 0 pin levels.
- R9: Every clock edge in a non-idle phase sets the port 0 latch to 0xFF, so its pins float after the bus cycle. CPU writes to port 0 at such an edge have no effect.
- R10: On port 3, a bit with `alt_en` set presents latch AND `alt_out`. The pin is pulled low when `alt_out` is 0 and released with pull-up when it is 1.
- R11: A port 3 latch bit whose `alt_en` is set is held at 1. Writes of 0 to that bit do not change what `rd_latch` shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Latch write strobe |
| wr_sel | input | 2 | Port chosen for the write |
| wr_data | input | 8 | Value to write to the latch |
| rd_sel | input | 2 | Port chosen for both read paths |
| rd_latch | output | 8 | Latch contents of the selected port |
| rd_pin | output | 8 | Pin levels of the selected port |
| xbus_phase | input | 2 | External bus phase (0 idle, 1 addr, 2 wdata, 3 rdata) |
| xbus_addr | input | 16 | External bus address |
| xbus_wdata | input | 8 | External bus write data |
| xbus_rdata | output | 8 | Port 0 pin levels for the read phase |
| alt_en | input | 8 | Port 3 alternate-function select per bit |
| alt_out | input | 8 | Port 3 alternate-function output per bit |
| pad_in | input | 32 | Resolved pin levels, port n at bits 8n+7:8n |
| pad_out | output | 32 | Value driven when the pin is enabled |
| pad_oe | output | 32 | Active drive enable per pin |
| pad_pu | output | 32 | Internal pull-up present per pin |

## Verification
The assertions take for granted that the pin level on `pad_in` follows the pad flags. A driven pin must show `pad_out`, so an external source never wins against active drive. They also assume `xbus_phase` holds only the four listed codes, and that `alt_en` changes at clock edges only. The bench resolves every pin from the pad flags before its own external sources are applied. It steps the bus phases in their order of use and changes `alt_en` only between edges, so the stimulus stays inside these assumptions.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

   localparam int NUM_PORTS  = 4;
   localparam int SEL_W      = $clog2(NUM_PORTS);
   localparam int PORT_BUSLO = 0;
   localparam int PORT_BUSHI = 2;
   localparam int PORT_ALT   = 3;

   typedef enum logic [1:0] {
      XB_IDLE  = 2'd0,
      XB_ADDR  = 2'd1,
      XB_WDATA = 2'd2,
      XB_RDATA = 2'd3
   } xbus_phase_e;

   typedef enum logic [1:0] {
      PK_OPEN_DRAIN = 2'd0,
      PK_QUASI      = 2'd1
   } pad_kind_e;

endpackage

// File: rtl/qbp_latch.sv
module qbp_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         force_ones,
   input  logic [W-1:0] hold_mask,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("qbp_latch: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          q <= '1;
      else if (force_ones) q <= '1;
      else if (wr)         q <= wdata | hold_mask;
      else                 q <= q | hold_mask;
   end

endmodule

// File: rtl/qbp_pad_ctrl.sv
module qbp_pad_ctrl #(
   parameter int                  W    = 8,
   parameter qbp_pkg::pad_kind_e  KIND = qbp_pkg::PK_QUASI
) (
   input  logic [W-1:0] level,
   input  logic         bus_on,
   input  logic         bus_drive,
   input  logic [W-1:0] bus_val,
   output logic [W-1:0] out,
   output logic [W-1:0] oe,
   output logic [W-1:0] pu
);

   if (KIND == qbp_pkg::PK_OPEN_DRAIN) begin : g_od
      assign pu = '0;
   end else begin : g_qb
      assign pu = '1;
   end

   always_comb begin
      if (bus_on) begin
         out = bus_val;
         oe  = bus_drive ? '1 : '0;
      end else begin
         out = '0;
         oe  = ~level;
      end
   end

endmodule

// File: rtl/qbport_bank.sv
module qbport_bank #(
   parameter int PORT_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [qbp_pkg::SEL_W-1:0]           wr_sel,
   input  logic [PORT_W-1:0]                   wr_data,
   input  logic [qbp_pkg::SEL_W-1:0]           rd_sel,
   output logic [PORT_W-1:0]                   rd_latch,
   output logic [PORT_W-1:0]                   rd_pin,
   input  logic [1:0]                          xbus_phase,
   input  logic [2*PORT_W-1:0]                 xbus_addr,
   input  logic [PORT_W-1:0]                   xbus_wdata,
   output logic [PORT_W-1:0]                   xbus_rdata,
   input  logic [PORT_W-1:0]                   alt_en,
   input  logic [PORT_W-1:0]                   alt_out,
   input  logic [qbp_pkg::NUM_PORTS*PORT_W-1:0] pad_in,
   output logic [qbp_pkg::NUM_PORTS*PORT_W-1:0] pad_out,
   output logic [qbp_pkg::NUM_PORTS*PORT_W-1:0] pad_oe,
   output logic [qbp_pkg::NUM_PORTS*PORT_W-1:0] pad_pu
);
   import qbp_pkg::*;

   localparam int TOT_W = NUM_PORTS * PORT_W;

   if (PORT_W < 2) begin : g_bad_width
      $error("qbport_bank: PORT_W must be at least 2");
   end

   xbus_phase_e phase;
   logic        bus_on;
   logic        bus_lo_drive;
   logic [PORT_W-1:0] bus_lo_val;
   logic [TOT_W-1:0]  latch_flat;

   assign phase        = xbus_phase_e'(xbus_phase);
   assign bus_on       = (phase != XB_IDLE);
   assign bus_lo_drive = (phase == XB_ADDR) || (phase == XB_WDATA);
   assign bus_lo_val   = (phase == XB_ADDR) ? xbus_addr[PORT_W-1:0] : xbus_wdata;

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      localparam pad_kind_e KIND = (i == PORT_BUSLO) ? PK_OPEN_DRAIN : PK_QUASI;
      logic [PORT_W-1:0] q;
      logic [PORT_W-1:0] level;
      logic [PORT_W-1:0] hold;
      logic              p_bus_on;
      logic              p_bus_drive;
      logic [PORT_W-1:0] p_bus_val;

      if (i == PORT_ALT) begin : g_alt
         assign hold  = alt_en;
         assign level = q & (alt_out | ~alt_en);
      end else begin : g_plain
         assign hold  = '0;
         assign level = q;
      end

      if (i == PORT_BUSLO) begin : g_buslo
         assign p_bus_on    = bus_on;
         assign p_bus_drive = bus_lo_drive;
         assign p_bus_val   = bus_lo_val;
      end else if (i == PORT_BUSHI) begin : g_bushi
         assign p_bus_on    = bus_on;
         assign p_bus_drive = 1'b1;
         assign p_bus_val   = xbus_addr[2*PORT_W-1:PORT_W];
      end else begin : g_nobus
         assign p_bus_on    = 1'b0;
         assign p_bus_drive = 1'b0;
         assign p_bus_val   = '0;
      end

      qbp_latch #(.W(PORT_W)) u_latch (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr         (wr_en && (wr_sel == SEL_W'(i))),
         .wdata      (wr_data),
         .force_ones ((i == PORT_BUSLO) && bus_on),
         .hold_mask  (hold),
         .q          (q)
      );

      qbp_pad_ctrl #(.W(PORT_W), .KIND(KIND)) u_pad (
         .level     (level),
         .bus_on    (p_bus_on),
         .bus_drive (p_bus_drive),
         .bus_val   (p_bus_val),
         .out       (pad_out[i*PORT_W +: PORT_W]),
         .oe        (pad_oe[i*PORT_W +: PORT_W]),
         .pu        (pad_pu[i*PORT_W +: PORT_W])
      );

      assign latch_flat[i*PORT_W +: PORT_W] = q;
   end

   assign rd_latch   = latch_flat[rd_sel*PORT_W +: PORT_W];
   assign rd_pin     = pad_in[rd_sel*PORT_W +: PORT_W];
   assign xbus_rdata = pad_in[PORT_BUSLO*PORT_W +: PORT_W];

endmodule

// File: rtl/qbport_bank_chk.sv
module qbport_bank_chk #(
   parameter int PORT_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            xbus_phase,
   input logic [2*PORT_W-1:0]   xbus_addr,
   input logic [PORT_W-1:0]     alt_en,
   input logic [PORT_W-1:0]     alt_out,
   input logic [4*PORT_W-1:0]   latch_flat,
   input logic [4*PORT_W-1:0]   pad_oe,
   input logic [4*PORT_W-1:0]   pad_out
);

   localparam logic [PORT_W-1:0] ONES = '1;

   AST_P0_FLOAT_ON_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (xbus_phase == 2'd0 && latch_flat[PORT_W-1:0] == ONES) |-> pad_oe[PORT_W-1:0] == '0); // R4

   AST_P1_ZERO_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      ((~latch_flat[2*PORT_W-1:PORT_W] & ~pad_oe[2*PORT_W-1:PORT_W]) == '0)); // R3

   AST_HI_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (xbus_phase != 2'd0) |-> (pad_oe[3*PORT_W-1:2*PORT_W] == ONES &&
                                pad_out[3*PORT_W-1:2*PORT_W] == xbus_addr[2*PORT_W-1:PORT_W])); // R7

   AST_BUS_SETS_P0: assert property (@(posedge clk) disable iff (!rst_n)
      (xbus_phase != 2'd0) |=> latch_flat[PORT_W-1:0] == ONES); // R9

   AST_ALT_LOW_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      ((alt_en & ~alt_out & ~pad_oe[4*PORT_W-1:3*PORT_W]) == '0)); // R10

   AST_ALT_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((latch_flat[4*PORT_W-1:3*PORT_W] & $past(alt_en)) == $past(alt_en))); // R11

endmodule

bind qbport_bank qbport_bank_chk #(.PORT_W(PORT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xbus_phase (xbus_phase),
   .xbus_addr  (xbus_addr),
   .alt_en     (alt_en),
   .alt_out    (alt_out),
   .latch_flat (latch_flat),
   .pad_oe     (pad_oe),
   .pad_out    (pad_out)
);

// File: tb/qbport_bank_bench.sv
`timescale 1ns/1ps
module qbport_bank_bench;

   localparam int W = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  wr_sel;
   logic [7:0]  wr_data;
   logic [1:0]  rd_sel;
   logic [7:0]  rd_latch;
   logic [7:0]  rd_pin;
   logic [1:0]  xbus_phase;
   logic [15:0] xbus_addr;
   logic [7:0]  xbus_wdata;
   logic [7:0]  xbus_rdata;
   logic [7:0]  alt_en;
   logic [7:0]  alt_out;
   logic [31:0] pad_in;
   logic [31:0] pad_out;
   logic [31:0] pad_oe;
   logic [31:0] pad_pu;
   logic [31:0] ext_en;
   logic [31:0] ext_val;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   qbport_bank #(.PORT_W(W)) u_qbport_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_latch(rd_latch), .rd_pin(rd_pin),
      .xbus_phase(xbus_phase), .xbus_addr(xbus_addr), .xbus_wdata(xbus_wdata),
      .xbus_rdata(xbus_rdata), .alt_en(alt_en), .alt_out(alt_out),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
   );

   always_comb begin
      for (int k = 0; k < 32; k++) begin
         if (pad_oe[k])      pad_in[k] = pad_out[k];
         else if (ext_en[k]) pad_in[k] = ext_val[k];
         else                pad_in[k] = pad_pu[k];
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_port(input logic [1:0] p, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = p; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_latch(input logic [1:0] p, output logic [7:0] v);
      rd_sel = p; #1; v = rd_latch;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      for (int p = 0; p < 4; p++) begin
         read_latch(p[1:0], v);
         check("R1 latch after reset", {24'd0, v}, 32'hFF);
      end
      check("R1 no pin driven", pad_oe, 32'h0);
      check("R4/R5 pull-up map", pad_pu, 32'hFFFF_FF00);
   endtask

   task automatic t_write_read();
      logic [7:0] v;
      write_port(2'd1, 8'h5A);
      write_port(2'd2, 8'hC3);
      read_latch(2'd1, v); check("R2 port1 readback", {24'd0, v}, 32'h5A);
      read_latch(2'd2, v); check("R2 port2 readback", {24'd0, v}, 32'hC3);
      check("R3 port1 drives zeros", {24'd0, pad_oe[15:8]}, 32'hA5);
      check("R3 port1 drives low", {24'd0, pad_out[15:8] & pad_oe[15:8]}, 32'h0);
   endtask

   task automatic t_mask();
      write_port(2'd1, 8'h0F);
      ext_en[15:8] = 8'hFF; ext_val[15:8] = 8'hFF;
      rd_sel = 2'd1; #1;
      check("R3 latched zeros mask external", {24'd0, rd_pin}, 32'h0F);
      ext_en[15:8] = 8'h00;
   endtask

   task automatic t_rmw();
      logic [7:0] v;
      write_port(2'd1, 8'hFF);
      ext_en[15:8] = 8'h04; ext_val[15:8] = 8'h00;
      read_latch(2'd1, v);
      check("R6 latch path unaffected", {24'd0, v}, 32'hFF);
      check("R6 pin path sees low", {24'd0, rd_pin}, 32'hFB);
      check("R5 released pins pulled high", {24'd0, pad_oe[15:8]}, 32'h00);
      ext_en[15:8] = 8'h00;
   endtask

   task automatic t_p0_open();
      write_port(2'd0, 8'hFF);
      rd_sel = 2'd0; #1;
      check("R4 port0 released", {24'd0, pad_oe[7:0]}, 32'h0);
      ext_en[7:0] = 8'hFF; ext_val[7:0] = 8'hA5; #1;
      check("R4 port0 reads external", {24'd0, rd_pin}, 32'hA5);
      ext_en[7:0] = 8'h00;
   endtask

   task automatic t_bus();
      logic [7:0] v;
      write_port(2'd2, 8'h3C);
      write_port(2'd0, 8'h00);
      @(negedge clk);
      xbus_phase = 2'd1; xbus_addr = 16'h1234; #1;
      check("R8 addr phase low byte", {24'd0, pad_out[7:0]}, 32'h34);
      check("R8 addr phase drive", {24'd0, pad_oe[7:0]}, 32'hFF);
      check("R7 high byte", {16'd0, pad_oe[23:16], pad_out[23:16]}, 32'hFF12);
      @(negedge clk);
      xbus_phase = 2'd2; xbus_wdata = 8'h5A;
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h00; #1;
      check("R8 wdata phase", {16'd0, pad_oe[7:0], pad_out[7:0]}, 32'hFF5A);
      @(negedge clk);
      wr_en = 1'b0;
      xbus_phase = 2'd3; ext_en[7:0] = 8'hFF; ext_val[7:0] = 8'hC3; #1;
      check("R8 rdata phase released", {24'd0, pad_oe[7:0]}, 32'h0);
      check("R8 rdata value", {24'd0, xbus_rdata}, 32'hC3);
      @(negedge clk);
      xbus_phase = 2'd0; ext_en[7:0] = 8'h00;
      read_latch(2'd0, v);
      check("R9 port0 latch forced, write ignored", {24'd0, v}, 32'hFF);
      read_latch(2'd2, v);
      check("R7 port2 latch kept", {24'd0, v}, 32'h3C);
      check("R7 port2 back to latch", {24'd0, pad_oe[23:16]}, 32'hC3);
   endtask

   task automatic t_alt();
      logic [7:0] v;
      @(negedge clk);
      alt_en = 8'h0F; alt_out = 8'h05;
      write_port(2'd3, 8'h00);
      read_latch(2'd3, v);
      check("R11 alt bits held at one", {24'd0, v}, 32'h0F);
      check("R10 gated with latch", {24'd0, pad_oe[31:24]}, 32'hFA);
      write_port(2'd3, 8'hFF);
      check("R10 alt signal on pin", {24'd0, pad_oe[31:24]}, 32'h0A);
      rd_sel = 2'd3; #1;
      check("R10 alt pin level", {24'd0, rd_pin}, 32'hF5);
      @(negedge clk);
      alt_en = 8'h00;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
      xbus_phase = 2'd0; xbus_addr = '0; xbus_wdata = '0;
      alt_en = '0; alt_out = '0; ext_en = '0; ext_val = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_read();
      t_mask();
      t_rmw();
      t_p0_open();
      t_bus();
      t_alt();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule